// File: doc/BRIEF.md
# Streaming Ethernet Test Frame Generator

This block sources Ethernet frames on a 64-bit streaming output for link bring-up and soak testing. Software programs it through a small word-addressed register port. The registers set the frame length policy, an optional frame quota, the gap policy between frames, and the destination and source MAC addresses. A single control bit starts and stops generation.

Each frame carries a 14-byte header followed by a payload whose content is fixed by its position in the frame. The header holds the destination address, the source address and a 2-byte field giving the total frame length. Frame length can be fixed, can sweep upward one byte per frame between two programmed bounds, or can be pseudo-random. Frames can be sent back to back or with random idle gaps between them. The FCS is not generated; the downstream MAC adds it.

Top module: `eth_pktgen`

## Requirements
- R1: After reset the registers read: size 0x25800040, count 0x0000000A, control 0x00000006, destination low 0x56780ADD, destination high 0x00001234, source low 0x43210ADD, source high 0x00008765. The output valid signal is low.
- R2: The registers sit at word addresses 0 size, 1 count, 2 control, 3 destination low, 4 destination high, 5 source low and 6 source high, and all of them read back what was written. Control bit 1 reads 1 while the generator is stopped and 0 while it runs. Writing the control register with bit 1 clear starts a run; writing it with bit 1 set stops the run.
- R3: Frame byte k travels on bits [8*(k mod 8)+7 : 8*(k mod 8)] of beat k/8.
  - Bytes 0 to 5 carry the destination address, most significant byte first.
  - Bytes 6 to 11 carry the source address in the same order.
  - Bytes 12 and 13 carry the total frame length, high byte first.
  - Every later byte k carries k mod 256.
  - Lanes beyond the frame end in the last beat are zero.
- R4: Start-of-packet is high only on the first beat and end-of-packet only on the last. The frame has ceil(length/8) beats. The empty count on the last beat equals (8 - length mod 8) mod 8.
- R5: With control bits [5:4] at 01 or 11 (fixed mode), every frame is size[13:0] bytes long. Lengths below 14 are sent as 14.
- R6: With control bits [5:4] at 10 (incremental mode), the first frame of a run is size[13:0] bytes long. Each following frame is one byte longer. After a frame of size[29:16] bytes, the length returns to size[13:0].
- R7: With control bits [5:4] at 00 (random mode), every frame length lies in 64..9600 bytes. The run continues until it is stopped, whatever the count register holds.
- R8: In a non-random mode with count bit 31 set, a run sends exactly count[30:0] frames and then stops by itself, so control bit 1 reads 1. A count of zero sends no frame. With bit 31 clear, the run continues until it is stopped.
- R9: A stop written during a frame lets that frame finish at its full length. No further frame starts.
- R10: With control bit 6 set, the next frame's first beat is presented in the cycle right after the previous frame's last beat is accepted.
- R11: With control bit 6 clear, between 0 and 15 idle cycles separate consecutive frames while ready stays high.
- R12: While valid is high and ready is low, the beat on the output is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i, combinational |
| tx_data_o | output | 64 | Frame data, byte 0 of a beat in bits [7:0] |
| tx_valid_o | output | 1 | Beat valid |
| tx_ready_i | input | 1 | Sink accepts the beat |
| tx_sop_o | output | 1 | First beat of a frame |
| tx_eop_o | output | 1 | Last beat of a frame |
| tx_empty_o | output | 3 | Unused bytes in the last beat |

## Verification
The hardest case to reach from the ports is a stop request that lands in the middle of a frame while the generator runs without a quota. The bench runs several gap-separated frames and watches the start-of-packet of the next one. In parallel with receiving that frame, it writes the stop, then checks that the frame arrives at full length and that the output stays silent afterwards. The incremental wrap is reached by setting bounds only ten bytes apart and asking for enough frames to wrap twice. The fixed-length sweep covers every residue modulo 8 under alternating backpressure.

// File: rtl/pktgen_pkg.sv
package pktgen_pkg;

  typedef enum logic [1:0] {
    LEN_RAND  = 2'b00,
    LEN_FIXED = 2'b01,
    LEN_INCR  = 2'b10,
    LEN_FIX2  = 2'b11
  } len_mode_e;

  localparam logic [2:0] REG_SIZE   = 3'd0;
  localparam logic [2:0] REG_COUNT  = 3'd1;
  localparam logic [2:0] REG_CTRL   = 3'd2;
  localparam logic [2:0] REG_DST_LO = 3'd3;
  localparam logic [2:0] REG_DST_HI = 3'd4;
  localparam logic [2:0] REG_SRC_LO = 3'd5;
  localparam logic [2:0] REG_SRC_HI = 3'd6;

  localparam int unsigned HDR_BYTES = 14;

  // byte at offset off of a frame of length len
  function automatic logic [7:0] frame_byte(input logic [15:0] off, input logic [47:0] dst,
                                            input logic [47:0] src, input logic [15:0] len);
    case (off)
      16'd0:   return dst[47:40];
      16'd1:   return dst[39:32];
      16'd2:   return dst[31:24];
      16'd3:   return dst[23:16];
      16'd4:   return dst[15:8];
      16'd5:   return dst[7:0];
      16'd6:   return src[47:40];
      16'd7:   return src[39:32];
      16'd8:   return src[31:24];
      16'd9:   return src[23:16];
      16'd10:  return src[15:8];
      16'd11:  return src[7:0];
      16'd12:  return len[15:8];
      16'd13:  return len[7:0];
      default: return off[7:0];
    endcase
  endfunction

endpackage

// File: rtl/pktgen_lfsr.sv
module pktgen_lfsr #(
  parameter int unsigned        W      = 32,
  parameter logic [W-1:0]       SEED   = 32'h1ACE_B00C,
  parameter logic [W-1:0]       TAPS   = 32'h8020_0003,
  parameter int unsigned        LEN_W  = 14,
  parameter int unsigned        GAP_W  = 4,
  parameter int unsigned        GAP_LO = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [LEN_W-1:0] rnd_len_o,
  output logic [GAP_W-1:0] rnd_gap_o
);

  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  assign rnd_len_o = state_q[LEN_W-1:0];
  assign rnd_gap_o = state_q[GAP_LO +: GAP_W];

  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) state_q != '0);

endmodule

// File: rtl/pktgen_regs.sv
module pktgen_regs
  import pktgen_pkg::*;
#(
  parameter int unsigned LEN_W  = 14,
  parameter int unsigned HI_OFF = 16,
  parameter int unsigned CNT_W  = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             done_i,
  output logic             run_o,
  output logic             start_o,
  output len_mode_e        mode_o,
  output logic             no_gap_o,
  output logic             cnt_en_o,
  output logic [CNT_W-1:0] cnt_tgt_o,
  output logic [LEN_W-1:0] size_lo_o,
  output logic [LEN_W-1:0] size_hi_o,
  output logic [47:0]      dst_o,
  output logic [47:0]      src_o
);

  logic [LEN_W-1:0] size_lo_q, size_hi_q;
  logic [31:0]      count_q;
  logic [7:2]       ctrl_hi_q;
  logic             ctrl_b0_q;
  logic             run_q;
  logic [31:0]      dst_lo_q, src_lo_q;
  logic [15:0]      dst_hi_q, src_hi_q;
  logic             ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == REG_CTRL);
  assign start_o = ctrl_wr && !wdata_i[1] && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_lo_q <= LEN_W'(64);
      size_hi_q <= LEN_W'(9600);
      count_q   <= 32'h0000_000A;
      ctrl_hi_q <= 6'b000001;
      ctrl_b0_q <= 1'b0;
      run_q     <= 1'b0;
      dst_lo_q  <= 32'h5678_0ADD;
      dst_hi_q  <= 16'h1234;
      src_lo_q  <= 32'h4321_0ADD;
      src_hi_q  <= 16'h8765;
    end else begin
      if (we_i) begin
        case (addr_i)
          REG_SIZE: begin
            size_lo_q <= wdata_i[LEN_W-1:0];
            size_hi_q <= wdata_i[HI_OFF +: LEN_W];
          end
          REG_COUNT:  count_q  <= wdata_i;
          REG_CTRL: begin
            ctrl_hi_q <= wdata_i[7:2];
            ctrl_b0_q <= wdata_i[0];
          end
          REG_DST_LO: dst_lo_q <= wdata_i;
          REG_DST_HI: dst_hi_q <= wdata_i[15:0];
          REG_SRC_LO: src_lo_q <= wdata_i;
          REG_SRC_HI: src_hi_q <= wdata_i[15:0];
          default: ;
        endcase
      end
      if (ctrl_wr)     run_q <= !wdata_i[1];
      else if (done_i) run_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_SIZE: begin
        rdata_o[LEN_W-1:0]       = size_lo_q;
        rdata_o[HI_OFF +: LEN_W] = size_hi_q;
      end
      REG_COUNT:  rdata_o = count_q;
      REG_CTRL:   rdata_o[7:0] = {ctrl_hi_q, !run_q, ctrl_b0_q};
      REG_DST_LO: rdata_o = dst_lo_q;
      REG_DST_HI: rdata_o[15:0] = dst_hi_q;
      REG_SRC_LO: rdata_o = src_lo_q;
      REG_SRC_HI: rdata_o[15:0] = src_hi_q;
      default: ;
    endcase
  end

  assign run_o     = run_q;
  assign mode_o    = len_mode_e'(ctrl_hi_q[5:4]);
  assign no_gap_o  = ctrl_hi_q[6];
  assign cnt_en_o  = count_q[31] && (mode_o != LEN_RAND);
  assign cnt_tgt_o = count_q[CNT_W-1:0];
  assign size_lo_o = size_lo_q;
  assign size_hi_o = size_hi_q;
  assign dst_o     = {dst_hi_q, dst_lo_q};
  assign src_o     = {src_hi_q, src_lo_q};

  // R8
  quota_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ctrl_wr |=> !run_q);

endmodule

// File: rtl/pktgen_len.sv
module pktgen_len
  import pktgen_pkg::*;
#(
  parameter int unsigned LEN_W        = 14,
  parameter int unsigned MIN_RAND_LEN = 64,
  parameter int unsigned MAX_RAND_LEN = 9600
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             take_i,
  input  len_mode_e        mode_i,
  input  logic [LEN_W-1:0] lo_i,
  input  logic [LEN_W-1:0] hi_i,
  input  logic [LEN_W-1:0] rnd_i,
  output logic [LEN_W-1:0] len_o
);

  localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] RMIN    = LEN_W'(MIN_RAND_LEN);
  localparam logic [LEN_W-1:0] RMAX    = LEN_W'(MAX_RAND_LEN);

  logic [LEN_W-1:0] inc_q, raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          inc_q <= RMIN;
    else if (start_i)                     inc_q <= lo_i;
    else if (take_i && mode_i == LEN_INCR) inc_q <= (inc_q >= hi_i) ? lo_i : inc_q + LEN_W'(1);
  end

  always_comb begin
    case (mode_i)
      LEN_RAND: raw = (rnd_i < RMIN) ? RMIN : (rnd_i > RMAX) ? RMAX : rnd_i;
      LEN_INCR: raw = inc_q;
      default:  raw = lo_i;
    endcase
    len_o = (raw < HDR_LEN) ? HDR_LEN : raw;
  end

  // R7
  rand_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == LEN_RAND |-> (len_o >= RMIN) && (len_o <= RMAX));

  // R6
  incr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !start_i && mode_i == LEN_INCR && inc_q < hi_i |=> inc_q == $past(inc_q) + LEN_W'(1));

endmodule

// File: rtl/pktgen_frame.sv
module pktgen_frame
  import pktgen_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LEN_W  = 14,
  parameter int unsigned GAP_W  = 4,
  parameter int unsigned CNT_W  = 31
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_i,
  input  logic                        start_i,
  input  logic                        no_gap_i,
  input  logic                        cnt_en_i,
  input  logic [CNT_W-1:0]            cnt_tgt_i,
  input  logic [LEN_W-1:0]            len_i,
  input  logic [GAP_W-1:0]            gap_i,
  input  logic [47:0]                 dst_i,
  input  logic [47:0]                 src_i,
  output logic                        take_o,
  output logic                        done_o,
  output logic [DATA_W-1:0]           tx_data_o,
  output logic                        tx_valid_o,
  input  logic                        tx_ready_i,
  output logic                        tx_sop_o,
  output logic                        tx_eop_o,
  output logic [$clog2(DATA_W/8)-1:0] tx_empty_o
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned BEAT_W = LEN_W - LANE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} st_e;

  st_e               state_q;
  logic [BEAT_W-1:0] beat_q;
  logic [LEN_W-1:0]  flen_q;
  logic [GAP_W-1:0]  gap_q;
  logic [CNT_W-1:0]  sent_q;
  logic              accept, last, quota_hit, quota_next, cont, launch;

  assign accept     = tx_valid_o && tx_ready_i;
  assign last       = ({1'b0, beat_q, {LANE_W{1'b0}}} + (LEN_W+1)'(LANES)) >= {1'b0, flen_q};
  assign quota_hit  = cnt_en_i && (sent_q >= cnt_tgt_i);
  assign quota_next = cnt_en_i && (({1'b0, sent_q} + (CNT_W+1)'(1)) >= {1'b0, cnt_tgt_i});
  assign cont       = run_i && !quota_next;

  always_comb begin
    case (state_q)
      ST_IDLE: launch = run_i && !quota_hit;
      ST_SEND: launch = accept && last && cont && (no_gap_i || gap_i == '0);
      ST_GAP:  launch = run_i && (gap_q == GAP_W'(1));
      default: launch = 1'b0;
    endcase
  end

  assign take_o = launch;
  assign done_o = (state_q == ST_IDLE) && run_i && quota_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      flen_q  <= LEN_W'(HDR_BYTES);
      gap_q   <= '0;
      sent_q  <= '0;
    end else begin
      if (start_i)            sent_q <= '0;
      else if (accept && last) sent_q <= sent_q + CNT_W'(1);
      if (launch) begin
        state_q <= ST_SEND;
        beat_q  <= '0;
        flen_q  <= len_i;
      end else begin
        case (state_q)
          ST_SEND: if (accept) begin
            if (!last)     beat_q <= beat_q + BEAT_W'(1);
            else if (cont) begin
              state_q <= ST_GAP;
              gap_q   <= gap_i;
            end else       state_q <= ST_IDLE;
          end
          ST_GAP: begin
            if (!run_i) state_q <= ST_IDLE;
            else        gap_q   <= gap_q - GAP_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_valid_o = (state_q == ST_SEND);
  assign tx_sop_o   = tx_valid_o && (beat_q == '0);
  assign tx_eop_o   = tx_valid_o && last;
  assign tx_empty_o = tx_eop_o ? (~flen_q[LANE_W-1:0]) + LANE_W'(1) : '0;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LEN_W-1:0] off;
    assign off = {beat_q, LANE_W'(j)};
    assign tx_data_o[8*j +: 8] = (off < flen_q) ? frame_byte(16'(off), dst_i, src_i, 16'(flen_q)) : 8'h00;
  end

  // R12
  hold_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(beat_q) && $stable(flen_q));

  // R10
  back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && tx_eop_o && no_gap_i && cont |=> tx_sop_o);

  // R8
  quota_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && tx_eop_o && quota_next |=> !tx_valid_o);

  // R5
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> flen_q >= LEN_W'(HDR_BYTES));

endmodule

// File: rtl/eth_pktgen.sv
module eth_pktgen
  import pktgen_pkg::*;
#(
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned LEN_W        = 14,
  parameter int unsigned GAP_W        = 4,
  parameter int unsigned MIN_RAND_LEN = 64,
  parameter int unsigned MAX_RAND_LEN = 9600,
  parameter logic [31:0] LFSR_SEED    = 32'h1ACE_B00C
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [2:0]                  cfg_addr_i,
  input  logic [31:0]                 cfg_wdata_i,
  output logic [31:0]                 cfg_rdata_o,
  output logic [DATA_W-1:0]           tx_data_o,
  output logic                        tx_valid_o,
  input  logic                        tx_ready_i,
  output logic                        tx_sop_o,
  output logic                        tx_eop_o,
  output logic [$clog2(DATA_W/8)-1:0] tx_empty_o
);

  localparam int unsigned CNT_W = 31;

  logic             run, start, no_gap, cnt_en, take, done;
  len_mode_e        mode;
  logic [CNT_W-1:0] cnt_tgt;
  logic [LEN_W-1:0] size_lo, size_hi, rnd_len, flen;
  logic [GAP_W-1:0] rnd_gap;
  logic [47:0]      dst, src;

  pktgen_regs #(.LEN_W(LEN_W), .HI_OFF(16), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .done_i(done), .run_o(run), .start_o(start), .mode_o(mode), .no_gap_o(no_gap),
    .cnt_en_o(cnt_en), .cnt_tgt_o(cnt_tgt), .size_lo_o(size_lo), .size_hi_o(size_hi),
    .dst_o(dst), .src_o(src)
  );

  pktgen_lfsr #(.W(32), .SEED(LFSR_SEED), .TAPS(32'h8020_0003),
                .LEN_W(LEN_W), .GAP_W(GAP_W), .GAP_LO(16)) u_lfsr (
    .clk_i, .rst_ni, .rnd_len_o(rnd_len), .rnd_gap_o(rnd_gap)
  );

  pktgen_len #(.LEN_W(LEN_W), .MIN_RAND_LEN(MIN_RAND_LEN), .MAX_RAND_LEN(MAX_RAND_LEN)) u_len (
    .clk_i, .rst_ni, .start_i(start), .take_i(take), .mode_i(mode),
    .lo_i(size_lo), .hi_i(size_hi), .rnd_i(rnd_len), .len_o(flen)
  );

  pktgen_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni, .run_i(run), .start_i(start), .no_gap_i(no_gap),
    .cnt_en_i(cnt_en), .cnt_tgt_i(cnt_tgt), .len_i(flen), .gap_i(rnd_gap),
    .dst_i(dst), .src_i(src), .take_o(take), .done_o(done),
    .tx_data_o, .tx_valid_o, .tx_ready_i, .tx_sop_o, .tx_eop_o, .tx_empty_o
  );

endmodule

// File: tb/eth_pktgen_bench.sv
module eth_pktgen_bench;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, ready = 1'b1;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [63:0] data;
  logic        valid, sop, eop;
  logic [2:0]  empty;

  int n_tests = 0, n_fail = 0;
  logic [7:0]  fb [0:16383];
  logic [47:0] dst_m = 48'h1234_5678_0ADD, src_m = 48'h8765_4321_0ADD;

  always #2 clk = ~clk;

  eth_pktgen u_eth_pktgen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .tx_data_o(data), .tx_valid_o(valid), .tx_ready_i(ready),
    .tx_sop_o(sop), .tx_eop_o(eop), .tx_empty_o(empty)
  );

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [7:0] exp_byte(input int o, input int len);
    if (o < 6)       return 8'(dst_m >> (8 * (5 - o)));
    else if (o < 12) return 8'(src_m >> (8 * (11 - o)));
    else if (o == 12) return 8'(len >> 8);
    else if (o == 13) return 8'(len);
    else             return 8'(o);
  endfunction

  // receive one frame; exp_len < 0 takes the length from the header
  task automatic recv(input int exp_len, input bit stall, input string req, output int got, output int gap);
    int beat = 0, ph = 0, emp = 0, bad = 0;
    bit fin = 0, held = 0, sop_err = 0;
    logic [63:0] hd = '0;
    gap = 0;
    while (!fin) begin
      @(negedge clk);
      ready = stall ? (ph % 3 != 1) : 1'b1;
      ph++;
      #1;
      if (held) begin
        check(valid && data == hd, "R12", "beat held under backpressure", data, hd);
        held = 0;
      end
      if (valid) begin
        if (!ready) begin
          held = 1; hd = data;
        end else begin
          if (beat == 0) check(sop, "R4", "sop on first beat", sop, 1);
          else if (sop) sop_err = 1;
          for (int j = 0; j < 8; j++) fb[beat*8+j] = data[8*j +: 8];
          if (eop) begin fin = 1; emp = empty; end
          beat++;
          if (beat >= 2048) fin = 1;
        end
      end else if (beat == 0) gap++;
    end
    ready = 1'b1;
    got = (exp_len < 0) ? int'({fb[12], fb[13]}) : exp_len;
    check(int'({fb[12], fb[13]}) == got, req, "length field", {fb[12], fb[13]}, got);
    check(beat == (got + 7) / 8, "R4", "beat count", beat, (got + 7) / 8);
    check(emp == (8 - got % 8) % 8, "R4", "empty count", emp, (8 - got % 8) % 8);
    check(!sop_err, "R4", "sop only on first beat", sop_err, 0);
    for (int o = 0; o < beat * 8; o++) begin
      logic [7:0] e;
      e = (o < got) ? exp_byte(o, got) : 8'h00;
      if (fb[o] != e && bad == 0) begin
        bad = 1;
        check(0, "R3", $sformatf("byte %0d", o), fb[o], e);
      end
    end
    if (bad == 0) check(1, "R3", "frame content", 0, 0);
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen = 0;
    repeat (n) begin @(negedge clk); #1 if (valid) seen = 1; end
    check(!seen, req, "no frame after end of run", seen, 0);
  endtask

  task automatic expect_stopped(input string req);
    logic [31:0] v;
    rd(3'd2, v);
    check(v[1], req, "control bit 1 reads stopped", v[1], 1);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int got, gap, nz;
    repeat (3) @(negedge clk);
    check(!valid, "R1", "valid low in reset", valid, 0);
    rst_n = 1'b1;
    rd(3'd0, v); check(v == 32'h2580_0040, "R1", "size reset", v, 32'h2580_0040);
    rd(3'd1, v); check(v == 32'h0000_000A, "R1", "count reset", v, 32'hA);
    rd(3'd2, v); check(v == 32'h0000_0006, "R1", "control reset", v, 32'h6);
    rd(3'd3, v); check(v == 32'h5678_0ADD, "R1", "dst low reset", v, 32'h5678_0ADD);
    rd(3'd4, v); check(v == 32'h0000_1234, "R1", "dst high reset", v, 32'h1234);
    rd(3'd5, v); check(v == 32'h4321_0ADD, "R1", "src low reset", v, 32'h4321_0ADD);
    rd(3'd6, v); check(v == 32'h0000_8765, "R1", "src high reset", v, 32'h8765);
    expect_quiet(10, "R1");

    // R2 readback with new addresses
    dst_m = 48'h02AB_CD12_3456; src_m = 48'h0A0B_0C0D_0E0F;
    wr(3'd3, dst_m[31:0]); wr(3'd4, {16'h0, dst_m[47:32]});
    wr(3'd5, src_m[31:0]); wr(3'd6, {16'h0, src_m[47:32]});
    wr(3'd1, 32'h8000_0003);
    rd(3'd3, v); check(v == dst_m[31:0], "R2", "dst low readback", v, dst_m[31:0]);
    rd(3'd4, v); check(v == {16'h0, dst_m[47:32]}, "R2", "dst high readback", v, dst_m[47:32]);
    rd(3'd5, v); check(v == src_m[31:0], "R2", "src low readback", v, src_m[31:0]);
    rd(3'd6, v); check(v == {16'h0, src_m[47:32]}, "R2", "src high readback", v, src_m[47:32]);
    rd(3'd1, v); check(v == 32'h8000_0003, "R2", "count readback", v, 32'h8000_0003);

    // R5 fixed sweep, one frame per run, alternating backpressure
    for (int l = 5; l <= 72; l++) begin
      if (l > 33 && l < 60) continue;
      wr(3'd0, (32'd9600 << 16) | l);
      wr(3'd1, 32'h8000_0001);
      wr(3'd2, (l == 20) ? 32'h70 : 32'h50);
      recv((l < 14) ? 14 : l, l[0], "R5", got, gap);
      expect_quiet(6, "R8");
      expect_stopped("R8");
    end

    // R6 incremental 60..70, 25 frames, no gaps
    wr(3'd0, (32'd70 << 16) | 32'd60);
    wr(3'd1, 32'h8000_0000 | 32'd25);
    wr(3'd2, 32'h60);
    for (int i = 0; i < 25; i++) begin
      recv(60 + (i % 11), 1'b0, "R6", got, gap);
      if (i > 0) check(gap == 0, "R10", "idle cycles between frames", gap, 0);
    end
    expect_quiet(20, "R8");
    expect_stopped("R8");

    // R8 zero quota
    wr(3'd0, (32'd9600 << 16) | 32'd64);
    wr(3'd1, 32'h8000_0000);
    wr(3'd2, 32'h50);
    expect_quiet(30, "R8");
    expect_stopped("R8");

    // R11 random gaps, unbounded run (bit 31 clear), then R9 stop mid-frame
    wr(3'd1, 32'h0000_0005);
    wr(3'd2, 32'h10);
    nz = 0;
    for (int i = 0; i < 6; i++) begin
      recv(64, 1'b0, "R11", got, gap);
      if (i > 0) begin
        check(gap <= 15, "R11", "gap bound", gap, 15);
        if (gap != 0) nz = 1;
      end
    end
    check(nz == 1, "R11", "some gap nonzero", nz, 1);
    fork
      recv(64, 1'b0, "R9", got, gap);
      begin
        do begin @(negedge clk); #1; end while (!(valid && sop));
        wr(3'd2, 32'h12);
      end
    join
    check(got == 64, "R9", "frame finished at full length", got, 64);
    expect_quiet(40, "R9");
    expect_stopped("R9");

    // R7 random lengths; quota bit ignored
    wr(3'd1, 32'h8000_0002);
    wr(3'd2, 32'h40);
    fork
      recv(-1, 1'b1, "R7", got, gap);
      begin
        repeat (3) @(negedge clk);
        rd(3'd2, v);
        check(!v[1], "R2", "control bit 1 reads running", v[1], 0);
      end
    join
    check(got >= 64 && got <= 9600, "R7", "random length range", got, 64);
    for (int i = 1; i < 3; i++) begin
      recv(-1, 1'b0, "R7", got, gap);
      check(got >= 64 && got <= 9600, "R7", "random length range", got, 64);
    end
    fork
      recv(-1, 1'b0, "R7", got, gap);
      begin repeat (2) @(negedge clk); wr(3'd2, 32'h42); end
    join
    check(got >= 64 && got <= 9600, "R7", "fourth frame past quota", got, 64);
    expect_quiet(40, "R9");
    expect_stopped("R7");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule